// File: doc/BRIEF.md
# Serial Clock-Calendar Register Space

This block is the two-wire serial slave of a clock-calendar. It holds one 256-byte space that a bus master reaches through an auto-incrementing word pointer. Six low addresses are backed by live time-of-day and date counters instead of plain storage, and three further addresses hold an hour/minute alarm and its sticky status flag. The counters advance on a one-cycle seconds tick. The rest of the space is general-purpose byte storage.

A transfer starts with the device address and a read/write bit. In a write, the first data byte sets the word pointer and each later byte is stored at the pointer. In a read, bytes are returned from the pointer onward. At every START the live counters are copied into a shadow set, and reads of the time addresses return that copy. A multi-byte read therefore cannot tear across a seconds carry. The system clock oversamples both bus lines. SDA is only ever pulled low through an open-drain enable.

Address map (all values binary): 0 seconds, 1 minutes, 2 hours, 3 day of month, 4 month, 5 year (two digits), 6 alarm minute, 7 alarm hour, 8 alarm status (bit 0). Addresses 9 to 255 are storage.

Top module: `rtc_i2c_regs`

## Requirements
- R1: The address byte is taken MSB first as seven address bits followed by the read/write bit (0 = write). The slave pulls SDA low in the acknowledge slot only when the seven bits equal SLAVE_ADDR (default 0x32). On a mismatch it leaves SDA released for that byte and for every byte up to the next START.
- R2: In a write, the first byte after the address loads the word pointer. Each later byte is stored at the pointer, acknowledged, and advances the pointer by one. A read returns the byte at the pointer, and the pointer advances after each byte. A master NACK ends the read.
- R3: The word pointer wraps from 255 to 0 during both writes and reads.
- R4: After reset the time reads 00:00:00, day 1, month 1, year 0. Both alarm registers read 0xFF, the status reads 0, and alarmOut is low.
- R5: Each secTick pulse advances the seconds. Seconds wrap after 59 and minutes wrap after 59, each carrying into the next field. Hours wrap after 23 and carry into the day. Months wrap after 12 and carry into the year, which wraps from 99 to 0.
- R6: The day wraps to 1 after the last day of the month: 30 for months 4, 6, 9 and 11, 31 for the other months, and 28 for February. February has 29 days when year mod 4 is 0.
- R7: Reads of addresses 0 to 5 return the values the counters held at the most recent START. A tick during the read does not change them.
- R8: Writing an address from 0 to 5 replaces the corresponding live counter at the end of that byte.
- R9: The status flag and alarmOut set when the hour and minute counters become equal to the alarm hour (address 7) and alarm minute (address 6).
- R10: Writing 0 to address 8 clears the flag. Writing any other value to it has no effect. Bit 0 of address 8 reads back the flag.
- R11: START and STOP are SDA falling and rising edges while SCL is high. SDA is pulled low only in acknowledge slots and for read data bits, and is released when the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| sdaDriveLow | output | 1 | Open-drain enable: 1 pulls SDA low |
| secTick | input | 1 | One-cycle pulse per second |
| alarmOut | output | 1 | Sticky alarm indication |

## Verification
Plain storage is tried with a run of distinct bytes, and again across address 255. The second case tells a wrapping pointer from a saturating one, and shows that a byte landing on address 0 reaches the seconds counter. The calendar is set just before rollover points: a 28-day February in a non-leap year, February in a leap year, a 30-day month, and year end. These four cases separate month-length errors from carry-chain errors. A tick is injected between two bytes of one read to tell a shadowed read from a live one. The alarm is cleared with a nonzero and then a zero write, which tells the clear rule apart from any write to the status address.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] day;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } calTime_t;

  // strobes from bus control to the register datapath
  typedef struct packed {
    logic       snap;
    logic       loadPtr;
    logic       wrByte;
    logic       incPtr;
    logic [7:0] data;
  } busStrobe_t;

  localparam int ADR_SEC    = 0;
  localparam int ADR_MIN    = 1;
  localparam int ADR_HOUR   = 2;
  localparam int ADR_DAY    = 3;
  localparam int ADR_MONTH  = 4;
  localparam int ADR_YEAR   = 5;
  localparam int ADR_AMIN   = 6;
  localparam int ADR_AHOUR  = 7;
  localparam int ADR_STATUS = 8;

  function automatic logic [7:0] monthLen(input logic [7:0] month, input logic [7:0] year);
    case (month)
      8'd2:                      monthLen = (year[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   monthLen = 8'd30;
      default:                   monthLen = 8'd31;
    endcase
  endfunction

  function automatic calTime_t advance(input calTime_t t);
    calTime_t n;
    n = t;
    if (t.sec < 8'd59) n.sec = t.sec + 8'd1;
    else begin
      n.sec = 8'd0;
      if (t.min < 8'd59) n.min = t.min + 8'd1;
      else begin
        n.min = 8'd0;
        if (t.hour < 8'd23) n.hour = t.hour + 8'd1;
        else begin
          n.hour = 8'd0;
          if (t.day < monthLen(t.month, t.year)) n.day = t.day + 8'd1;
          else begin
            n.day = 8'd1;
            if (t.month < 8'd12) n.month = t.month + 8'd1;
            else begin
              n.month = 8'd1;
              n.year  = (t.year < 8'd99) ? t.year + 8'd1 : 8'd0;
            end
          end
        end
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/rtc_bus_ctrl.sv
module rtc_bus_ctrl
  import rtc_cal_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rdData,
  output logic       sdaDriveLow,
  output busStrobe_t strb
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WRITE, ST_WRITE_ACK, ST_READ, ST_READ_ACK
  } busState_t;

  busState_t state;
  logic [1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev;
  logic [3:0] bitCnt;
  logic [7:0] shReg, txByte;
  logic isRead, ptrPending, driveLow;
  logic sclRise, sclFall, startSeen, stopSeen, sdaNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign sdaNow    = sdaSync[1];
  assign sclRise   = sclSync[1] & ~sclPrev;
  assign sclFall   = ~sclSync[1] & sclPrev;
  assign startSeen = sclSync[1] & sclPrev & sdaPrev & ~sdaNow;
  assign stopSeen  = sclSync[1] & sclPrev & ~sdaPrev & sdaNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      shReg      <= '0;
      txByte     <= '0;
      isRead     <= 1'b0;
      ptrPending <= 1'b0;
      driveLow   <= 1'b0;
      strb       <= '0;
    end else begin
      strb <= '0;
      if (startSeen) begin
        state      <= ST_ADDR;
        bitCnt     <= '0;
        driveLow   <= 1'b0;
        ptrPending <= 1'b1;
        strb.snap  <= 1'b1;
      end else if (stopSeen) begin
        state    <= ST_IDLE;
        driveLow <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WRITE: begin
            if (sclRise) begin
              shReg  <= {shReg[6:0], sdaNow};
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              if (state == ST_ADDR) begin
                if (shReg[7:1] == SLAVE_ADDR) begin
                  state    <= ST_ADDR_ACK;
                  driveLow <= 1'b1;
                  isRead   <= shReg[0];
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                state     <= ST_WRITE_ACK;
                driveLow  <= 1'b1;
                strb.data <= shReg;
                if (ptrPending) begin
                  strb.loadPtr <= 1'b1;
                  ptrPending   <= 1'b0;
                end else begin
                  strb.wrByte <= 1'b1;
                end
              end
            end
          end
          ST_ADDR_ACK: if (sclFall) begin
            bitCnt <= '0;
            if (isRead) begin
              state    <= ST_READ;
              txByte   <= rdData;
              driveLow <= ~rdData[7];
            end else begin
              state    <= ST_WRITE;
              driveLow <= 1'b0;
            end
          end
          ST_WRITE_ACK: if (sclFall) begin
            state    <= ST_WRITE;
            bitCnt   <= '0;
            driveLow <= 1'b0;
          end
          ST_READ: begin
            if (sclRise) bitCnt <= bitCnt + 4'd1;
            else if (sclFall) begin
              if (bitCnt == 4'd8) begin
                state       <= ST_READ_ACK;
                driveLow    <= 1'b0;
                strb.incPtr <= 1'b1;
              end else begin
                driveLow <= ~txByte[3'd7 - bitCnt[2:0]];
              end
            end
          end
          ST_READ_ACK: begin
            if (sclRise && sdaNow) state <= ST_IDLE;
            else if (sclFall) begin
              state    <= ST_READ;
              bitCnt   <= '0;
              txByte   <= rdData;
              driveLow <= ~rdData[7];
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdaDriveLow = driveLow;

  // R1
  addr_ack_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR_ACK && $past(state) != ST_ADDR_ACK) |-> (shReg[7:1] == SLAVE_ADDR))
    else $error("ack given to a foreign address");

  // R11
  drive_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    driveLow |-> (state == ST_ADDR_ACK || state == ST_WRITE_ACK || state == ST_READ))
    else $error("SDA pulled low outside an ack or read slot");

endmodule

// File: rtl/rtc_reg_space.sv
module rtc_reg_space
  import rtc_cal_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       secTick,
  input  busStrobe_t strb,
  output logic [7:0] rdData,
  output logic       alarmOut
);

  localparam int DEPTH = 1 << PTR_W;

  logic [7:0] mem [DEPTH];
  logic [PTR_W-1:0] ptr;
  calTime_t timeCur, timeSnap, timeNext;
  logic [7:0] alarmMin, alarmHour;
  logic alarmFlag, matchPrev, matchNow, clearHit;

  always_comb begin
    timeNext = secTick ? advance(timeCur) : timeCur;
    if (strb.wrByte) begin
      case (ptr)
        PTR_W'(ADR_SEC):   timeNext.sec   = strb.data;
        PTR_W'(ADR_MIN):   timeNext.min   = strb.data;
        PTR_W'(ADR_HOUR):  timeNext.hour  = strb.data;
        PTR_W'(ADR_DAY):   timeNext.day   = strb.data;
        PTR_W'(ADR_MONTH): timeNext.month = strb.data;
        PTR_W'(ADR_YEAR):  timeNext.year  = strb.data;
        default: ;
      endcase
    end
  end

  assign matchNow = (timeCur.hour == alarmHour) && (timeCur.min == alarmMin);
  assign clearHit = strb.wrByte && (ptr == PTR_W'(ADR_STATUS)) && (strb.data == 8'd0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeCur   <= '{year: 8'd0, month: 8'd1, day: 8'd1, hour: 8'd0, min: 8'd0, sec: 8'd0};
      timeSnap  <= '{year: 8'd0, month: 8'd1, day: 8'd1, hour: 8'd0, min: 8'd0, sec: 8'd0};
      ptr       <= '0;
      alarmMin  <= 8'hFF;
      alarmHour <= 8'hFF;
      alarmFlag <= 1'b0;
      matchPrev <= 1'b0;
    end else begin
      timeCur   <= timeNext;
      matchPrev <= matchNow;
      if (strb.snap) timeSnap <= timeCur;
      if (strb.loadPtr) ptr <= PTR_W'(strb.data);
      else if (strb.wrByte || strb.incPtr) ptr <= ptr + 1'b1;
      if (strb.wrByte && ptr == PTR_W'(ADR_AMIN))  alarmMin  <= strb.data;
      if (strb.wrByte && ptr == PTR_W'(ADR_AHOUR)) alarmHour <= strb.data;
      if (matchNow && !matchPrev) alarmFlag <= 1'b1;
      else if (clearHit) alarmFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.wrByte) mem[ptr] <= strb.data;
  end

  always_comb begin
    rdData = mem[ptr];
    case (ptr)
      PTR_W'(ADR_SEC):    rdData = timeSnap.sec;
      PTR_W'(ADR_MIN):    rdData = timeSnap.min;
      PTR_W'(ADR_HOUR):   rdData = timeSnap.hour;
      PTR_W'(ADR_DAY):    rdData = timeSnap.day;
      PTR_W'(ADR_MONTH):  rdData = timeSnap.month;
      PTR_W'(ADR_YEAR):   rdData = timeSnap.year;
      PTR_W'(ADR_AMIN):   rdData = alarmMin;
      PTR_W'(ADR_AHOUR):  rdData = alarmHour;
      PTR_W'(ADR_STATUS): rdData = {7'd0, alarmFlag};
      default: ;
    endcase
  end

  assign alarmOut = alarmFlag;

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrByte || strb.incPtr) |=> (ptr == $past(ptr) + 1'b1))
    else $error("pointer did not step by one");

  // R5
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && timeCur.sec == 8'd59 && !strb.wrByte) |=> (timeCur.sec == 8'd0))
    else $error("seconds did not wrap");

  // R7
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.snap |=> $stable(timeSnap))
    else $error("shadow changed without START");

  // R9
  alarm_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmFlag) |-> ($past(timeCur.hour) == $past(alarmHour) && $past(timeCur.min) == $past(alarmMin)))
    else $error("alarm set without a match");

  // R10
  alarm_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(alarmFlag) |-> $past(clearHit))
    else $error("alarm cleared without a zero write");

endmodule

// File: rtl/rtc_i2c_regs.sv
module rtc_i2c_regs
  import rtc_cal_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h32,
  parameter int         PTR_W      = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaDriveLow,
  input  logic secTick,
  output logic alarmOut
);

  busStrobe_t strb;
  logic [7:0] rdData;

  rtc_bus_ctrl #(.SLAVE_ADDR(SLAVE_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdData(rdData), .sdaDriveLow(sdaDriveLow), .strb(strb)
  );

  rtc_reg_space #(.PTR_W(PTR_W)) u_regs (
    .clk(clk), .rstN(rstN), .secTick(secTick), .strb(strb),
    .rdData(rdData), .alarmOut(alarmOut)
  );

endmodule

// File: tb/rtc_i2c_regs_bench.sv
module rtc_i2c_regs_bench;
  localparam logic [6:0] DEV = 7'h32;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclReg = 1'b1;
  logic tbSdaLow = 1'b0;
  logic secTick = 1'b0;
  logic sdaDriveLow, alarmOut, sdaLine;
  int checks = 0;
  int failures = 0;
  logic [7:0] rdBuf [0:9];

  assign sdaLine = ~(tbSdaLow | sdaDriveLow);

  always #10 clk = ~clk;

  rtc_i2c_regs #(.SLAVE_ADDR(DEV)) u_rtc_i2c_regs (
    .clk(clk), .rstN(rstN), .sclIn(sclReg), .sdaIn(sdaLine),
    .sdaDriveLow(sdaDriveLow), .secTick(secTick), .alarmOut(alarmOut)
  );

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic i2cStart();
    tbSdaLow = 1'b0; idle(Q);
    sclReg = 1'b1;   idle(Q);
    tbSdaLow = 1'b1; idle(Q);
    sclReg = 1'b0;   idle(2);
  endtask

  task automatic i2cStop();
    tbSdaLow = 1'b1; idle(Q);
    sclReg = 1'b1;   idle(Q);
    tbSdaLow = 1'b0; idle(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      tbSdaLow = ~b[i]; idle(Q);
      sclReg = 1'b1;    idle(Q);
      sclReg = 1'b0;    idle(2);
    end
    tbSdaLow = 1'b0; idle(Q);
    sclReg = 1'b1;   idle(Q / 2);
    ack = ~sdaLine;  idle(Q / 2);
    sclReg = 1'b0;   idle(2);
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    tbSdaLow = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      idle(Q);
      sclReg = 1'b1; idle(Q / 2);
      b[i] = sdaLine; idle(Q / 2);
      sclReg = 1'b0; idle(2);
    end
    tbSdaLow = ackIt; idle(Q);
    sclReg = 1'b1;    idle(Q);
    sclReg = 1'b0;    idle(2);
    tbSdaLow = 1'b0;
  endtask

  task automatic writeSeq(input logic [7:0] addr, input logic [63:0] data, input int n);
    logic ack;
    i2cStart();
    sendByte({DEV, 1'b0}, ack); check("R1 address ack on write", {7'd0, ack}, 8'd1);
    sendByte(addr, ack);        check("R2 pointer byte ack", {7'd0, ack}, 8'd1);
    for (int i = 0; i < n; i++) begin
      sendByte(data[8*i +: 8], ack); check("R2 data byte ack", {7'd0, ack}, 8'd1);
    end
    i2cStop();
  endtask

  task automatic readSeq(input logic [7:0] addr, input int n);
    logic ack;
    logic [7:0] b;
    i2cStart();
    sendByte({DEV, 1'b0}, ack);
    sendByte(addr, ack);
    i2cStart();
    sendByte({DEV, 1'b1}, ack); check("R1 address ack on read", {7'd0, ack}, 8'd1);
    for (int i = 0; i < n; i++) begin
      recvByte(i != n - 1, b);
      rdBuf[i] = b;
    end
    i2cStop();
  endtask

  task automatic pulseTick();
    secTick = 1'b1; idle(1);
    secTick = 1'b0; idle(1);
  endtask

  task automatic testReset();
    logic [7:0] exp [0:8];
    exp = '{8'd0, 8'd0, 8'd0, 8'd1, 8'd1, 8'd0, 8'hFF, 8'hFF, 8'd0};
    check("R4 alarmOut after reset", {7'd0, alarmOut}, 8'd0);
    check("R11 SDA released after reset", {7'd0, sdaDriveLow}, 8'd0);
    readSeq(8'd0, 9);
    for (int i = 0; i < 9; i++) check("R4 reset register value", rdBuf[i], exp[i]);
    check("R11 SDA released after STOP", {7'd0, sdaDriveLow}, 8'd0);
  endtask

  task automatic testMismatch();
    logic ack;
    i2cStart();
    sendByte({DEV ^ 7'h05, 1'b0}, ack); check("R1 foreign address NACK", {7'd0, ack}, 8'd0);
    sendByte(8'h20, ack);               check("R1 byte after foreign address NACK", {7'd0, ack}, 8'd0);
    i2cStop();
  endtask

  task automatic testRam();
    writeSeq(8'h20, 64'h5A3CA5, 3);
    readSeq(8'h20, 3);
    check("R2 storage byte 0", rdBuf[0], 8'hA5);
    check("R2 storage byte 1", rdBuf[1], 8'h3C);
    check("R2 storage byte 2", rdBuf[2], 8'h5A);
  endtask

  task automatic testWrap();
    writeSeq(8'hFF, 64'h2277, 2);
    readSeq(8'hFF, 2);
    check("R3 byte at 255", rdBuf[0], 8'h77);
    check("R3 R8 wrapped write lands in seconds", rdBuf[1], 8'h22);
  endtask

  task automatic rollCase(input string tag, input logic [47:0] setv, input logic [47:0] expv);
    writeSeq(8'd0, {16'd0, setv}, 6);
    pulseTick();
    readSeq(8'd0, 6);
    for (int i = 0; i < 6; i++) check(tag, rdBuf[i], expv[8*i +: 8]);
  endtask

  task automatic testRollover();
    rollCase("R5 R6 R8 non-leap February end",
      {8'd23, 8'd2, 8'd28, 8'd23, 8'd59, 8'd59}, {8'd23, 8'd3, 8'd1, 8'd0, 8'd0, 8'd0});
    rollCase("R6 leap February 28th",
      {8'd24, 8'd2, 8'd28, 8'd23, 8'd59, 8'd59}, {8'd24, 8'd2, 8'd29, 8'd0, 8'd0, 8'd0});
    rollCase("R6 thirty-day month end",
      {8'd5, 8'd4, 8'd30, 8'd23, 8'd59, 8'd59}, {8'd5, 8'd5, 8'd1, 8'd0, 8'd0, 8'd0});
    rollCase("R5 year end wrap",
      {8'd99, 8'd12, 8'd31, 8'd23, 8'd59, 8'd59}, {8'd0, 8'd1, 8'd1, 8'd0, 8'd0, 8'd0});
  endtask

  task automatic testSnapshot();
    logic ack;
    logic [7:0] b;
    writeSeq(8'd0, 64'h00003B, 3);
    i2cStart();
    sendByte({DEV, 1'b0}, ack);
    sendByte(8'd0, ack);
    i2cStart();
    sendByte({DEV, 1'b1}, ack);
    recvByte(1'b1, b); check("R7 shadow seconds", b, 8'd59);
    pulseTick();
    recvByte(1'b0, b); check("R7 shadow minutes unchanged by tick", b, 8'd0);
    i2cStop();
    readSeq(8'd0, 2);
    check("R5 seconds after carry", rdBuf[0], 8'd0);
    check("R5 minutes after carry", rdBuf[1], 8'd1);
  endtask

  task automatic testAlarm();
    writeSeq(8'd0, 64'h00003B, 3);
    writeSeq(8'd6, 64'h0001, 2);
    check("R9 no alarm before match", {7'd0, alarmOut}, 8'd0);
    pulseTick();
    idle(3);
    check("R9 alarm on hour:minute match", {7'd0, alarmOut}, 8'd1);
    writeSeq(8'd8, 64'h05, 1);
    check("R10 nonzero status write ignored", {7'd0, alarmOut}, 8'd1);
    readSeq(8'd8, 1);
    check("R10 status bit reads set", rdBuf[0], 8'd1);
    writeSeq(8'd8, 64'h00, 1);
    check("R10 zero write clears alarm", {7'd0, alarmOut}, 8'd0);
    readSeq(8'd8, 1);
    check("R10 status bit reads clear", rdBuf[0], 8'd0);
  endtask

  initial begin
    idle(5);
    rstN = 1'b1;
    idle(5);
    testReset();
    testMismatch();
    testRam();
    testWrap();
    testRollover();
    testSnapshot();
    testAlarm();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule